// File: doc/BRIEF.md
# Paged Shared-Memory Address Translator

This block sits between a LAN controller, the host and a board's buffer RAM. It turns addresses into physical RAM addresses through a page map that software loads. The map has 1024 entries of 16 bits. Each entry names a physical page frame, says whether the bytes of that page are exchanged, and says whether the page is in on-board memory or on an auxiliary memory bus. The map has no valid or protection bits, so every access goes through its entry.

The controller issues 24-bit addresses. The block ignores the top four bits. Bits [19:10] pick a map entry and bits [9:0] are the byte offset inside a 1024-byte page. The host issues 20-bit window addresses that use the same index and offset split, and the same map serves both. Results are registered, so each one appears one cycle after its request. When a controller page is marked for exchange, the two bytes of each 16-bit write word are swapped on the way to memory. If a page is in on-board memory and its frame number is at or beyond the board's frame count, the access is flagged and not issued.

The host loads and reads the map through a word-indexed register port. The map has no reset value, so software must load an entry before any access uses it. The last entry covers the top of the controller's space. Pointing it at a low frame makes a structure in that frame appear at the fixed high address 0xFFFFF4.

Top module: `pgmap_xlat`

## Requirements
- R1: Controller address bits [23:20] have no effect: two addresses that differ only in those bits give identical outputs.
- R2: A request at clock edge N gives, after edge N, a valid flag and a physical address equal to {entry frame bits [11:0], address bits [9:0]}. A cycle with no request gives valid, out-of-range, swap and aux all 0.
- R3: The swap output equals bit 15 of the addressed entry. When that bit is 1, the controller write word leaves as mem_wdata with its upper and lower bytes exchanged. When it is 0, the word leaves unchanged. Both take effect with the same one-cycle latency as the address.
- R4: The aux output equals bit 13 of the addressed entry: 1 selects the auxiliary memory bus and 0 selects on-board memory.
- R5: Host lookups use the same map as controller lookups: host address bits [19:10] index the map and bits [9:0] are the offset. The host path gives the same translation as a controller access with the same low 20 bits.
- R6: If entry bit 13 is 0 and the frame field is 256 or more, the out-of-range output is 1 and valid is 0. If entry bit 13 is 1, the frame field is not range-checked.
- R7: A register write stores reg_wdata at entry reg_idx. A register read of reg_idx returns that entry on reg_rdata after the next clock edge, and reg_rdata holds its value until the next read.
- R8: Every entry translates, with no valid bits. The last entry (index 1023) set to frame 0 maps controller address 0xFFFFF4 to physical address 0x0003F4.
- R9: A lookup in the same cycle as a map write to the same entry uses the entry's previous contents. Later lookups use the new contents.
- R10: During and after reset, before any request, valid, out-of-range, swap, aux, physical address, mem_wdata and reg_rdata are all 0 on both paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write map entry reg_idx |
| reg_rd | input | 1 | Read map entry reg_idx |
| reg_idx | input | 10 | Map entry index |
| reg_wdata | input | 16 | Map entry write value |
| reg_rdata | output | 16 | Map entry read value (registered) |
| ctl_req | input | 1 | Controller access request |
| ctl_addr | input | 24 | Controller address |
| ctl_wdata | input | 16 | Controller write word |
| hst_req | input | 1 | Host access request |
| hst_addr | input | 20 | Host window address |
| ctl_vld | output | 1 | Controller translation valid |
| ctl_oor | output | 1 | Controller frame out of range |
| ctl_swap | output | 1 | Controller page byte exchange |
| ctl_aux | output | 1 | Controller page on auxiliary bus |
| ctl_phys | output | 22 | Controller physical address |
| mem_wdata | output | 16 | Controller write word after exchange |
| hst_vld | output | 1 | Host translation valid |
| hst_oor | output | 1 | Host frame out of range |
| hst_swap | output | 1 | Host page byte exchange |
| hst_aux | output | 1 | Host page on auxiliary bus |
| hst_phys | output | 22 | Host physical address |

## Verification
The bench aims at the frame limit from both sides: frame 255 must pass and frame 256 must be flagged. A design with an off-by-one compare would suppress a legal page or issue an access to missing RAM. It also sets the aux bit on a large frame, which a design that checked range regardless of bus would wrongly flag. It sends controller addresses with a nonzero top nibble and the 0xFFFFF4 alias through the last entry; a design that decoded too many index bits would pick the wrong entry. It also issues a lookup in the same cycle as a write to that entry, which catches a map that forwards new data too early, and it sends swapped and unswapped write words so that a reversed polarity shows up as exchanged bytes.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    localparam int ENTRY_W = 16;
    localparam int FRAME_W = 12;

    // Map entry layout: bit positions are decoded by the lookup stage.
    typedef struct packed {
        logic               swap;    // 15: exchange bytes of each word
        logic               rsv_hi;  // 14
        logic               aux;     // 13: page on auxiliary bus
        logic               rsv_lo;  // 12
        logic [FRAME_W-1:0] frame;   // 11:0 physical frame
    } map_entry_t;

endpackage

// File: rtl/pgx_map_store.sv
module pgx_map_store
    import pgx_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int NRD   = 3
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  map_entry_t           wr_data,
    input  logic [IDX_W-1:0]     rd_idx  [NRD],
    output map_entry_t           rd_data [NRD]
);
    localparam int DEPTH = 1 << IDX_W;

    // Map storage has no reset; software loads it before use.
    map_entry_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = mem_q[rd_idx[p]];
    end

endmodule

// File: rtl/pgx_lookup.sv
module pgx_lookup
    import pgx_pkg::*;
#(
    parameter int OFF_W   = 10,
    parameter int NFRAMES = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req,
    input  logic [OFF_W-1:0]           offset,
    input  map_entry_t                 entry,
    output logic                       vld,
    output logic                       oor,
    output logic                       swap,
    output logic                       aux,
    output logic [FRAME_W+OFF_W-1:0]   phys
);
    localparam int PHYS_W = FRAME_W + OFF_W;
    localparam logic [FRAME_W:0] FRAME_LIM = NFRAMES[FRAME_W:0];

    typedef struct packed {
        logic              vld;
        logic              oor;
        logic              swap;
        logic              aux;
        logic [PHYS_W-1:0] phys;
    } res_t;

    res_t res_d, res_q;
    logic in_range;

    always_comb begin
        res_d    = '0;
        in_range = entry.aux || ({1'b0, entry.frame} < FRAME_LIM);
        if (req) begin
            res_d.vld  = in_range;
            res_d.oor  = !in_range;
            res_d.swap = entry.swap;
            res_d.aux  = entry.aux;
            res_d.phys = {entry.frame, offset};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign vld  = res_q.vld;
    assign oor  = res_q.oor;
    assign swap = res_q.swap;
    assign aux  = res_q.aux;
    assign phys = res_q.phys;

endmodule

// File: rtl/pgx_swap_stage.sv
module pgx_swap_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              swap,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] wdata_out
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] word_d, word_q;

    always_comb begin
        word_d = '0;
        if (req) begin
            word_d = swap ? {wdata[HALF-1:0], wdata[DATA_W-1:HALF]} : wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign wdata_out = word_q;

endmodule

// File: rtl/pgx_reg_port.sv
module pgx_reg_port
    import pgx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd,
    input  map_entry_t         entry,
    output logic [ENTRY_W-1:0] rdata
);
    logic [ENTRY_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (rd) rdata_d = entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/pgmap_xlat.sv
module pgmap_xlat
    import pgx_pkg::*;
#(
    parameter int CTL_AW  = 24,
    parameter int OFF_W   = 10,
    parameter int IDX_W   = 10,
    parameter int NFRAMES = 256,
    parameter int DATA_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [IDX_W-1:0]           reg_idx,
    input  logic [ENTRY_W-1:0]         reg_wdata,
    output logic [ENTRY_W-1:0]         reg_rdata,
    input  logic                       ctl_req,
    input  logic [CTL_AW-1:0]          ctl_addr,
    input  logic [DATA_W-1:0]          ctl_wdata,
    input  logic                       hst_req,
    input  logic [IDX_W+OFF_W-1:0]     hst_addr,
    output logic                       ctl_vld,
    output logic                       ctl_oor,
    output logic                       ctl_swap,
    output logic                       ctl_aux,
    output logic [FRAME_W+OFF_W-1:0]   ctl_phys,
    output logic [DATA_W-1:0]          mem_wdata,
    output logic                       hst_vld,
    output logic                       hst_oor,
    output logic                       hst_swap,
    output logic                       hst_aux,
    output logic [FRAME_W+OFF_W-1:0]   hst_phys
);
    localparam int WIN_W  = IDX_W + OFF_W;
    localparam int PHYS_W = FRAME_W + OFF_W;
    localparam int NLK    = 2;          // 0: controller, 1: host
    localparam int RD_REG = NLK;        // register read port
    localparam int NRD    = NLK + 1;

    logic [IDX_W-1:0] rd_idx  [NRD];
    map_entry_t       rd_data [NRD];

    logic             lk_req [NLK];
    logic [OFF_W-1:0] lk_off [NLK];
    logic             lk_vld [NLK];
    logic             lk_oor [NLK];
    logic             lk_swp [NLK];
    logic             lk_aux [NLK];
    logic [PHYS_W-1:0] lk_phys [NLK];

    // Controller top bits above the window are dropped here.
    logic [WIN_W-1:0] ctl_win;
    assign ctl_win = ctl_addr[WIN_W-1:0];

    assign lk_req[0] = ctl_req;
    assign lk_off[0] = ctl_win[OFF_W-1:0];
    assign rd_idx[0] = ctl_win[WIN_W-1:OFF_W];
    assign lk_req[1] = hst_req;
    assign lk_off[1] = hst_addr[OFF_W-1:0];
    assign rd_idx[1] = hst_addr[WIN_W-1:OFF_W];
    assign rd_idx[RD_REG] = reg_idx;

    pgx_map_store #(.IDX_W(IDX_W), .NRD(NRD)) u_store (
        .clk     (clk),
        .wr_en   (reg_wr),
        .wr_idx  (reg_idx),
        .wr_data (map_entry_t'(reg_wdata)),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    for (genvar k = 0; k < NLK; k++) begin : g_lk
        pgx_lookup #(.OFF_W(OFF_W), .NFRAMES(NFRAMES)) u_lookup (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (lk_req[k]),
            .offset (lk_off[k]),
            .entry  (rd_data[k]),
            .vld    (lk_vld[k]),
            .oor    (lk_oor[k]),
            .swap   (lk_swp[k]),
            .aux    (lk_aux[k]),
            .phys   (lk_phys[k])
        );
    end

    pgx_swap_stage #(.DATA_W(DATA_W)) u_swap (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ctl_req),
        .swap      (rd_data[0].swap),
        .wdata     (ctl_wdata),
        .wdata_out (mem_wdata)
    );

    pgx_reg_port u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (reg_rd),
        .entry (rd_data[RD_REG]),
        .rdata (reg_rdata)
    );

    assign ctl_vld  = lk_vld[0];
    assign ctl_oor  = lk_oor[0];
    assign ctl_swap = lk_swp[0];
    assign ctl_aux  = lk_aux[0];
    assign ctl_phys = lk_phys[0];
    assign hst_vld  = lk_vld[1];
    assign hst_oor  = lk_oor[1];
    assign hst_swap = lk_swp[1];
    assign hst_aux  = lk_aux[1];
    assign hst_phys = lk_phys[1];

endmodule

// File: rtl/pgx_chk.sv
module pgx_chk #(
    parameter int PHYS_W  = 22,
    parameter int OFF_W   = 10,
    parameter int NFRAMES = 256,
    parameter int DATA_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_req,
    input logic              hst_req,
    input logic [DATA_W-1:0] ctl_wdata,
    input logic              ctl_vld,
    input logic              ctl_oor,
    input logic              ctl_swap,
    input logic              ctl_aux,
    input logic [PHYS_W-1:0] ctl_phys,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              hst_vld,
    input logic              hst_oor,
    input logic              hst_aux,
    input logic [PHYS_W-1:0] hst_phys
);
    localparam int HALF = DATA_W / 2;

    // R2
    ctl_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_req |=> (ctl_vld || ctl_oor));

    // R2
    ctl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_req |=> (!ctl_vld && !ctl_oor && !ctl_swap && !ctl_aux));

    // R2
    hst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_req |=> (!hst_vld && !hst_oor));

    // R6
    ctl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_vld && ctl_oor));

    // R6
    ctl_oor_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_oor |-> (!ctl_aux && (ctl_phys[PHYS_W-1:OFF_W] >= NFRAMES)));

    // R6
    hst_oor_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_oor |-> (!hst_aux && (hst_phys[PHYS_W-1:OFF_W] >= NFRAMES)));

    // R3
    keep_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_vld && !ctl_swap) |-> (mem_wdata == $past(ctl_wdata)));

    // R3
    swap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_vld && ctl_swap) |->
            (mem_wdata == {$past(ctl_wdata[HALF-1:0]), $past(ctl_wdata[DATA_W-1:HALF])}));

endmodule

bind pgmap_xlat pgx_chk #(
    .PHYS_W  (FRAME_W + OFF_W),
    .OFF_W   (OFF_W),
    .NFRAMES (NFRAMES),
    .DATA_W  (DATA_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_req   (ctl_req),
    .hst_req   (hst_req),
    .ctl_wdata (ctl_wdata),
    .ctl_vld   (ctl_vld),
    .ctl_oor   (ctl_oor),
    .ctl_swap  (ctl_swap),
    .ctl_aux   (ctl_aux),
    .ctl_phys  (ctl_phys),
    .mem_wdata (mem_wdata),
    .hst_vld   (hst_vld),
    .hst_oor   (hst_oor),
    .hst_aux   (hst_aux),
    .hst_phys  (hst_phys)
);

// File: tb/test_pgmap_xlat.sv
module test_pgmap_xlat;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [9:0]  reg_idx = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        ctl_req = 0;
    logic [23:0] ctl_addr = '0;
    logic [15:0] ctl_wdata = '0;
    logic        hst_req = 0;
    logic [19:0] hst_addr = '0;
    logic        ctl_vld, ctl_oor, ctl_swap, ctl_aux;
    logic [21:0] ctl_phys;
    logic [15:0] mem_wdata;
    logic        hst_vld, hst_oor, hst_swap, hst_aux;
    logic [21:0] hst_phys;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgmap_xlat i_pgmap_xlat (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ctl_req(ctl_req), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
        .hst_req(hst_req), .hst_addr(hst_addr),
        .ctl_vld(ctl_vld), .ctl_oor(ctl_oor), .ctl_swap(ctl_swap),
        .ctl_aux(ctl_aux), .ctl_phys(ctl_phys), .mem_wdata(mem_wdata),
        .hst_vld(hst_vld), .hst_oor(hst_oor), .hst_swap(hst_swap),
        .hst_aux(hst_aux), .hst_phys(hst_phys)
    );

    typedef struct packed {
        logic        vld;
        logic        oor;
        logic        swap;
        logic        aux;
        logic [21:0] phys;
        logic [15:0] wd;
    } exp_t;

    typedef struct {
        exp_t  ctl;
        exp_t  hst;
        string tag;
    } item_t;

    logic [15:0] model [1024];
    item_t       sb_q [$];

    function automatic exp_t predict(input logic [15:0] e, input logic [9:0] off,
                                     input logic [15:0] wd, input bit req);
        exp_t r = '0;
        bit   ok;
        if (req) begin
            ok     = e[13] || (e[11:0] < 12'd256);
            r.vld  = ok;
            r.oor  = !ok;
            r.swap = e[15];
            r.aux  = e[13];
            r.phys = {e[11:0], off};
            r.wd   = e[15] ? {wd[7:0], wd[15:8]} : wd;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares one queued expectation per cycle after the edge.
    always @(posedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            item_t it;
            exp_t  ac, ah, eh;
            it = sb_q.pop_front();
            ac = {ctl_vld, ctl_oor, ctl_swap, ctl_aux, ctl_phys, mem_wdata};
            ah = {hst_vld, hst_oor, hst_swap, hst_aux, hst_phys, 16'h0};
            eh = it.hst;
            eh.wd = '0;
            check(ac == it.ctl, {it.tag, " ctl"}, 64'(ac), 64'(it.ctl));
            check(ah == eh, {it.tag, " hst"}, 64'(ah), 64'(eh));
        end
    end

    task automatic map_write(input logic [9:0] idx, input logic [15:0] val);
        @(negedge clk);
        reg_wr = 1; reg_idx = idx; reg_wdata = val;
        @(negedge clk);
        reg_wr = 0;
        model[idx] = val;
    endtask

    task automatic map_read(input logic [9:0] idx, input string tag);
        @(negedge clk);
        reg_rd = 1; reg_idx = idx;
        @(posedge clk);
        #2;
        check(reg_rdata == model[idx], tag, 64'(reg_rdata), 64'(model[idx]));
        @(negedge clk);
        reg_rd = 0;
    endtask

    // Driver: one cycle on both paths, optional map write in the same cycle.
    task automatic xlat(input bit cv, input logic [23:0] ca, input logic [15:0] cw,
                        input bit hv, input logic [19:0] ha, input string tag,
                        input bit wv = 0, input logic [9:0] wi = '0,
                        input logic [15:0] wdv = '0);
        item_t it;
        @(negedge clk);
        ctl_req = cv; ctl_addr = ca; ctl_wdata = cw;
        hst_req = hv; hst_addr = ha;
        reg_wr = wv; reg_idx = wi; reg_wdata = wdv;
        it.ctl = predict(model[ca[19:10]], ca[9:0], cw, cv);
        it.hst = predict(model[ha[19:10]], ha[9:0], 16'h0, hv);
        it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk);
        if (wv) model[wi] = wdv;
        @(negedge clk);
        ctl_req = 0; hst_req = 0; reg_wr = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state
        check({ctl_vld, ctl_oor, ctl_swap, ctl_aux, ctl_phys, mem_wdata,
               hst_vld, hst_oor, hst_swap, hst_aux, hst_phys, reg_rdata} == '0,
              "R10 reset outputs", 64'({ctl_vld, ctl_oor, hst_vld, hst_oor}), 64'h0);
        @(negedge clk);
        rst_n = 1;
        repeat (2) @(posedge clk);
        #2;
        check({ctl_vld, hst_vld, reg_rdata} == '0, "R10 after reset",
              64'({ctl_vld, hst_vld, reg_rdata}), 64'h0);

        // load map
        map_write(10'd0,    16'h8003);   // swapped, frame 3
        map_write(10'd1,    16'h0005);   // plain, frame 5
        map_write(10'd2,    16'h2FF0);   // aux bus, large frame
        map_write(10'd3,    16'h00FF);   // frame 255
        map_write(10'd4,    16'h0100);   // frame 256
        map_write(10'd5,    16'hA010);   // swapped + aux
        map_write(10'd1023, 16'h8000);   // alias to frame 0

        // R7: readback
        map_read(10'd0, "R7 read idx0");
        map_read(10'd4, "R7 read idx4");
        map_read(10'd1023, "R7 read idx1023");
        @(negedge clk);
        repeat (2) @(posedge clk);
        #2;
        check(reg_rdata == model[1023], "R7 rdata holds", 64'(reg_rdata), 64'(model[1023]));

        // R2 / R3: plain and swapped pages
        xlat(1, 24'h000412, 16'h1234, 0, '0, "R2 plain page");
        xlat(1, 24'h000010, 16'hABCD, 0, '0, "R3 swapped page");
        // R1: top nibble ignored
        xlat(1, 24'hF00412, 16'h1234, 0, '0, "R1 top nibble F");
        xlat(1, 24'h500010, 16'hABCD, 0, '0, "R1 top nibble 5");
        // R4: aux bus and no range check
        xlat(1, 24'h000801, 16'h00FF, 0, '0, "R4 aux page");
        xlat(1, 24'h001402, 16'h5A5A, 0, '0, "R4 swapped aux page");
        // R6: frame limit both sides
        xlat(1, 24'h000C07, 16'h0001, 0, '0, "R6 frame 255");
        xlat(1, 24'h0013FF, 16'h0002, 0, '0, "R6 frame 256");
        // R5: host path, alone and together with controller
        xlat(0, '0, '0, 1, 20'h00412, "R5 host plain");
        xlat(0, '0, '0, 1, 20'h01001, "R5 host frame 256");
        xlat(1, 24'h000020, 16'hBEEF, 1, 20'h00C00, "R5 both paths");
        // R8: high alias
        xlat(1, 24'hFFFFF4, 16'hCAFE, 0, '0, "R8 alias 0xFFFFF4");
        xlat(0, '0, '0, 1, 20'hFFFF4, "R8 host alias");
        // R9: same-cycle write uses old entry, then new one
        xlat(1, 24'h000400, 16'h7788, 0, '0, "R9 same cycle old entry", 1, 10'd1, 16'h8100);
        xlat(1, 24'h000400, 16'h7788, 0, '0, "R9 next cycle new entry");
        // R2: idle cycle after traffic
        xlat(0, 24'h000412, 16'h1111, 0, 20'h00412, "R2 idle");

        repeat (3) @(posedge clk);
        #3;
        finish_run();
    end

endmodule